// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle datapath that carries out one register-transfer microoperation on every clock edge. A 16-bit control word, applied for one cycle, chooses two source registers, the operand on the second bus, the operation of an internal function unit, the source of the write-back bus, and whether a register is loaded at all. Eight general registers of `WIDTH` bits each sit in a register file with two asynchronous read ports and one synchronous write port.

The first read bus leaves the block as a memory address. The second read bus, or an external constant, leaves the block as write data. Clearing the write-enable bit turns a cycle into a pure memory or output write. Selecting the external data input as the write-back source turns a cycle into a memory read. A sequencer outside the block supplies the control words. Memory and instruction fetch also live outside.

The function unit covers arithmetic, bitwise logic and single-position shifts. It reports overflow, carry, sign and zero flags combinationally from its own result. All ports are plain level signals with no handshake, because every microoperation completes in exactly one cycle and no back-pressure can arise.

Top module: `cw_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to zero.
- R2: Control word fields are: destination address bits [15:13], A address bits [12:10], B address bits [9:7], B-source select bit [6], function select bits [5:2], D-source select bit [1], write enable bit [0]. Each address is the binary register index 0..7. `addr_out` always equals the register named by the A address.
- R3: With bit [6] = 0, `data_out` equals the register named by the B address. With bit [6] = 1, it equals `const_in`. This value is the function unit's B operand.
- R4: With bit [0] = 1, the D bus value is written into the register named by the destination address at the rising edge. With bit [0] = 0, no register changes.
- R5: With bit [1] = 0, the D bus carries the function unit result. With bit [1] = 1, it carries `data_in`.
- R6: Arithmetic select codes: 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A-B, 0110 A-1, 0111 A (computed as A+~0+1). All results are modulo 2^WIDTH.
- R7: Logic select codes: 1000 A AND B, 1001 A OR B, 1010 A XOR B, 1011 NOT A.
- R8: Shift select codes: 1100 B, 1101 B shifted right by one with zero fill, 1110 B shifted left by one with zero fill, 1111 B.
- R9: For arithmetic codes, `flag_c` is the adder carry out and `flag_v` is two's-complement overflow of the signed sum. For logic and shift codes, both are 0.
- R10: `flag_n` is the result's most significant bit, and `flag_z` is 1 exactly when the result is all zeros. Both reflect the function unit result whatever the D-source select.
- R11: A register read in the same cycle as a write to that register returns the old value. A register-to-register operation such as R0 <- R1 + R2 is visible on the read ports in the cycle right after it is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 16 | Microoperation control word |
| const_in | input | WIDTH | External constant for the B bus |
| data_in | input | WIDTH | External data for the D bus (memory read) |
| addr_out | output | WIDTH | A bus, used as memory address |
| data_out | output | WIDTH | B bus, used as memory write data |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result sign |
| flag_z | output | 1 | Result zero |

## Verification
A write to a register and a read of that same register can fall in one cycle. The bench provokes this with control words whose destination equals the A or B address, both in directed steps and at random. It judges the outcome by expecting the pre-write value on `addr_out` and `data_out` in that cycle and the new value one cycle later. A second overlap is a load through `data_in` while the function unit still computes a result. There the flags must follow the discarded function result, while the register takes the external value.

// File: rtl/cw_dp_pkg.sv
package cw_dp_pkg;

  localparam int CW_BITS  = 16;
  localparam int RADDR_W  = 3;
  localparam int NUM_REGS = 1 << RADDR_W;

  // Field order is fixed by the control word layout (MSB first).
  typedef struct packed {
    logic [RADDR_W-1:0] dst;
    logic [RADDR_W-1:0] srca;
    logic [RADDR_W-1:0] srcb;
    logic               bsel_const;
    logic [3:0]         fsel;
    logic               dsel_ext;
    logic               wr_en;
  } ctrl_t;

  typedef enum logic [3:0] {
    FS_PASS_A   = 4'b0000,
    FS_INC      = 4'b0001,
    FS_ADD      = 4'b0010,
    FS_ADD_C    = 4'b0011,
    FS_ADD_NB   = 4'b0100,
    FS_SUB      = 4'b0101,
    FS_DEC      = 4'b0110,
    FS_PASS_A_C = 4'b0111,
    FS_AND      = 4'b1000,
    FS_OR       = 4'b1001,
    FS_XOR      = 4'b1010,
    FS_NOT      = 4'b1011,
    FS_PASS_B   = 4'b1100,
    FS_SHR      = 4'b1101,
    FS_SHL      = 4'b1110,
    FS_SPARE    = 4'b1111
  } fsel_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;

endpackage

// File: rtl/cw_regfile.sv
module cw_regfile #(
  parameter int WIDTH   = 16,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [WIDTH-1:0]  rdata_a,
  output logic [WIDTH-1:0]  rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][WIDTH-1:0] regs_q;
  logic [DEPTH-1:0]            sel_w;

  // One-hot write decode
  always_comb begin
    sel_w = '0;
    sel_w[waddr] = we;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[i] <= '0;
      else if (sel_w[i])
        regs_q[i] <= wdata;
    end
  end

  // Asynchronous reads: old value visible during a write cycle
  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rdata_a == '0 && rdata_b == '0)); // R1

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs_q)); // R4

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> regs_q[$past(waddr)] == $past(wdata)); // R4

endmodule

// File: rtl/cw_arith_unit.sv
module cw_arith_unit #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       ysel,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y_op;
  logic [WIDTH:0]   total;

  // Second adder operand: zero, B, inverted B, all ones
  always_comb begin
    unique case (ysel)
      2'b00:   y_op = '0;
      2'b01:   y_op = opb;
      2'b10:   y_op = ~opb;
      default: y_op = '1;
    endcase
  end

  assign total = {1'b0, opa} + {1'b0, y_op} + {{WIDTH{1'b0}}, cin};
  assign sum   = total[MSB:0];
  assign cout  = total[WIDTH];
  assign ovf   = (opa[MSB] == y_op[MSB]) && (total[MSB] != opa[MSB]);

endmodule

// File: rtl/cw_logic_shift.sv
module cw_logic_shift #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             shift_grp,
  input  logic [1:0]       op,
  output logic [WIDTH-1:0] res
);

  logic [WIDTH-1:0] logic_r;
  logic [WIDTH-1:0] shift_r;

  always_comb begin
    unique case (op)
      2'b00:   logic_r = opa & opb;
      2'b01:   logic_r = opa | opb;
      2'b10:   logic_r = opa ^ opb;
      default: logic_r = ~opa;
    endcase
  end

  always_comb begin
    unique case (op)
      2'b01:   shift_r = {1'b0, opb[WIDTH-1:1]};
      2'b10:   shift_r = {opb[WIDTH-2:0], 1'b0};
      default: shift_r = opb;
    endcase
  end

  assign res = shift_grp ? shift_r : logic_r;

endmodule

// File: rtl/cw_function_unit.sv
module cw_function_unit
  import cw_dp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       fsel,
  output logic [WIDTH-1:0] result,
  output flags_t           flags
);

  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] ls_res;
  logic             a_cout;
  logic             a_ovf;
  logic             is_arith;

  assign is_arith = ~fsel[3];

  cw_arith_unit #(.WIDTH(WIDTH)) u_arith (
    .opa  (opa),
    .opb  (opb),
    .ysel (fsel[2:1]),
    .cin  (fsel[0]),
    .sum  (arith_res),
    .cout (a_cout),
    .ovf  (a_ovf)
  );

  cw_logic_shift #(.WIDTH(WIDTH)) u_ls (
    .opa       (opa),
    .opb       (opb),
    .shift_grp (fsel[2]),
    .op        (fsel[1:0]),
    .res       (ls_res)
  );

  assign result  = is_arith ? arith_res : ls_res;
  assign flags.v = is_arith & a_ovf;
  assign flags.c = is_arith & a_cout;
  assign flags.n = result[WIDTH-1];
  assign flags.z = (result == '0);

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_dp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW_BITS-1:0] ctrl_word,
  input  logic [WIDTH-1:0]   const_in,
  input  logic [WIDTH-1:0]   data_in,
  output logic [WIDTH-1:0]   addr_out,
  output logic [WIDTH-1:0]   data_out,
  output logic               flag_v,
  output logic               flag_c,
  output logic               flag_n,
  output logic               flag_z
);

  ctrl_t            cw;
  logic [WIDTH-1:0] bus_a;
  logic [WIDTH-1:0] reg_b;
  logic [WIDTH-1:0] bus_b;
  logic [WIDTH-1:0] bus_d;
  logic [WIDTH-1:0] fu_res;
  flags_t           fu_flags;

  assign cw = ctrl_t'(ctrl_word);

  cw_regfile #(.WIDTH(WIDTH), .ADDR_W(RADDR_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (cw.wr_en),
    .waddr   (cw.dst),
    .wdata   (bus_d),
    .raddr_a (cw.srca),
    .raddr_b (cw.srcb),
    .rdata_a (bus_a),
    .rdata_b (reg_b)
  );

  // B bus source: register or external constant
  assign bus_b = cw.bsel_const ? const_in : reg_b;

  cw_function_unit #(.WIDTH(WIDTH)) u_fu (
    .opa    (bus_a),
    .opb    (bus_b),
    .fsel   (cw.fsel),
    .result (fu_res),
    .flags  (fu_flags)
  );

  // D bus source: function result or external data (memory read)
  assign bus_d = cw.dsel_ext ? data_in : fu_res;

  assign addr_out = bus_a;
  assign data_out = bus_b;
  assign flag_v   = fu_flags.v;
  assign flag_c   = fu_flags.c;
  assign flag_n   = fu_flags.n;
  assign flag_z   = fu_flags.z;

  AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cw.fsel == FS_SUB && bus_a == bus_b) |-> (flag_z && flag_c && !flag_v)); // R9

  AST_NONARITH_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    cw.fsel[3] |-> (!flag_c && !flag_v)); // R9

  AST_EXT_LOAD_IS_DATA_IN: assert property (@(posedge clk) disable iff (rst)
    (cw.wr_en && cw.dsel_ext && cw.srca == cw.dst) ##1 (cw.srca == $past(cw.dst))
      |-> addr_out == $past(data_in)); // R5

  AST_PASS_B_SHOWS_BUS_B: assert property (@(posedge clk) disable iff (rst)
    (cw.fsel == FS_PASS_B) |-> (flag_z == (data_out == '0))); // R10

endmodule

// File: tb/cw_datapath_bench.sv
module cw_datapath_bench;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   ctrl_word = '0;
  logic [W-1:0]  const_in = '0;
  logic [W-1:0]  data_in = '0;
  logic [W-1:0]  addr_out, data_out;
  logic          flag_v, flag_c, flag_n, flag_z;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [8];

  always #5 clk = ~clk;

  cw_datapath #(.WIDTH(W)) u_cw_datapath (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete, act=hung exp=done");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(input int da, input int aa, input int ba,
      input bit mb, input logic [3:0] fs, input bit md, input bit rw);
    return {da[2:0], aa[2:0], ba[2:0], mb, fs, md, rw};
  endfunction

  // Behavioural function unit model, from the select-code table
  task automatic fu_model(input logic [3:0] fs, input logic [W-1:0] a,
      input logic [W-1:0] b, output logic [W-1:0] r, output bit c, output bit v);
    longint ua = a, ub = b, sum;
    longint sa = longint'($signed(a)), sb = longint'($signed(b)), sres;
    c = 0; v = 0;
    if (fs[3] == 1'b0) begin
      case (fs[2:0])
        3'd0: begin sum = ua;                   sres = sa;          end
        3'd1: begin sum = ua + 1;               sres = sa + 1;      end
        3'd2: begin sum = ua + ub;              sres = sa + sb;     end
        3'd3: begin sum = ua + ub + 1;          sres = sa + sb + 1; end
        3'd4: begin sum = ua + (65535 - ub);    sres = sa - sb - 1; end
        3'd5: begin sum = ua + (65535 - ub) + 1; sres = sa - sb;    end
        3'd6: begin sum = ua + 65535;           sres = sa - 1;      end
        default: begin sum = ua + 65536;        sres = sa;          end
      endcase
      r = sum[W-1:0];
      c = (sum > 65535);
      v = (sres > 32767) || (sres < -32768);
    end else begin
      case (fs)
        4'b1000: r = a & b;
        4'b1001: r = a | b;
        4'b1010: r = a ^ b;
        4'b1011: r = ~a;
        4'b1101: r = b >> 1;
        4'b1110: r = b << 1;
        default: r = b;
      endcase
    end
  endtask

  // One microoperation: drive at negedge, compare mid-cycle, then update model
  task automatic step(input logic [15:0] cw, input logic [W-1:0] k,
                      input logic [W-1:0] din, input string tag);
    logic [W-1:0] ea, eb, er;
    bit ec, ev;
    string fr;
    @(negedge clk);
    ctrl_word = cw; const_in = k; data_in = din;
    #2;
    ea = model[cw[12:10]];
    eb = cw[6] ? k : model[cw[9:7]];
    fu_model(cw[5:2], ea, eb, er, ec, ev);
    fr = (cw[5] == 1'b0) ? "R6" : (cw[4] == 1'b0) ? "R7" : "R8";
    chk(addr_out == ea, {tag, " R2 addr_out"}, 32'(addr_out), 32'(ea));
    chk(data_out == eb, {tag, " R3 data_out"}, 32'(data_out), 32'(eb));
    chk({flag_n, flag_z} == {er[W-1], er == '0}, {fr, " R10 N/Z"},
        32'({flag_n, flag_z}), 32'({er[W-1], er == '0}));
    chk({flag_v, flag_c} == {ev, ec}, {fr, " R9 V/C"},
        32'({flag_v, flag_c}), 32'({ev, ec}));
    if (cw[0]) model[cw[15:13]] = cw[1] ? din : er;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) step(mk(0, i, 7 - i, 0, 4'b1100, 0, 0), '0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    sweep("R1 reset");
    // Loads through data_in
    for (int i = 1; i < 8; i++)
      step(mk(i, 0, 0, 0, 4'b0010, 1, 1), '0, 16'(i * 16'h1111), "R5 ext load");
    sweep("R5 readback");
    // R0 <- R1 + R2, then visible next cycle
    step(mk(0, 1, 2, 0, 4'b0010, 0, 1), '0, 16'hdead, "R6 add");
    step(mk(0, 0, 0, 0, 4'b0000, 0, 0), '0, '0, "R11 one-cycle result");
    // Same-cycle read/write of one register
    step(mk(3, 3, 3, 0, 4'b0001, 0, 1), '0, '0, "R11 old value");
    step(mk(0, 3, 3, 0, 4'b0000, 0, 0), '0, '0, "R11 new value");
    // Write suppressed
    step(mk(4, 1, 2, 0, 4'b0010, 0, 0), '0, 16'hbeef, "R4 no write");
    step(mk(4, 1, 2, 1, 4'b0010, 1, 0), 16'h5555, 16'hbeef, "R4 no write ext");
    sweep("R4 unchanged");
    // Constant on B bus, overflow corners
    step(mk(5, 5, 0, 1, 4'b0010, 0, 1), 16'h1234, '0, "R3 constant");
    step(mk(6, 0, 0, 0, 4'b0000, 1, 1), '0, 16'h7fff, "R5 load 7fff");
    step(mk(7, 0, 0, 0, 4'b0000, 1, 1), '0, 16'h8000, "R5 load 8000");
    step(mk(1, 6, 0, 0, 4'b0001, 0, 1), '0, '0, "R9 inc overflow");
    step(mk(2, 7, 0, 0, 4'b0110, 0, 1), '0, '0, "R9 dec overflow");
    step(mk(2, 7, 7, 0, 4'b0101, 0, 1), '0, '0, "R9 sub self zero");
    step(mk(2, 6, 7, 0, 4'b0010, 0, 1), '0, '0, "R6 add mixed");
    step(mk(2, 7, 0, 1, 4'b0101, 0, 1), 16'h0001, '0, "R9 sub overflow");
    for (int f = 0; f < 16; f++)
      step(mk(f % 8, 6, 7, 0, 4'(f), 0, 1), '0, '0, "R6 R7 R8 code sweep");
    sweep("R8 readback");
    // Random traffic with periodic sweeps
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] cw = 16'($urandom);
      logic [W-1:0] k = (n % 5 == 0) ? 16'hffff : 16'($urandom);
      logic [W-1:0] d = (n % 7 == 0) ? 16'h8000 : 16'($urandom);
      step(cw, k, d, "R4 R5 R11 random");
      if (n % 100 == 99) sweep("R4 random readback");
    end
    // Reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    sweep("R1 second reset");
    finish_run();
  end

endmodule